// File: doc/BRIEF.md
# Multi-Mode 8x8 Multiplier

This block forms a 16-bit product from two 8-bit operands in one of six arithmetic modes. Three base modes choose how the operands are read: both unsigned, both signed, or a signed first operand times an unsigned second operand. A fractional variant of each base mode doubles the result by shifting it one place to the left. The caller supplies the two operand values, the register indices they came from, a 3-bit mode and a start strobe. The block returns the product, a zero flag, a carry flag, a one-cycle done pulse and a writeback enable.

Each mode may only draw its operands from a given window of the 32-entry register file. The block checks both indices against the window for the selected mode. When an index falls outside the window, or the mode code is reserved, the block reports an error in place of a writeback. On a legal operation the low product byte is meant for register 0 and the high byte for register 1. Those register writes are left to the surrounding datapath, which sees only `prod` and `wb_en`.

Top module: `mulx_unit`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `busy`, `done`, `err`, `wb_en`, `flag_z` and `flag_c` are 0 and `prod` is 0.
- R2: Mode code 3'b000 (unsigned times unsigned) treats both operands as unsigned and accepts any index 0..31 for either operand.
- R3: Mode code 3'b001 (signed times signed) treats both operands as two's complement and accepts only indices 16..31.
- R4: Mode code 3'b010 (mixed) sign-extends `op_a`, zero-extends `op_b`, and accepts only indices 16..23.
- R5: Setting `mode[2]` selects the fractional variant of the base mode in `mode[1:0]`. The 16-bit product is shifted left one bit, and the index window for all three fractional modes is 16..23.
- R6: `flag_c` is bit 15 of the product before any fractional shift. `flag_z` is 1 exactly when the 16-bit value presented on `prod` is zero.
- R7: A `start` sampled while idle raises `busy` for the next cycle. In the cycle after that, `done` is high for exactly one cycle and `busy` is low. A `start` sampled while `busy` is high is ignored.
- R8: An illegal index for the selected mode, or base mode `mode[1:0]` = 2'b11, gives `err` high together with `done`. In that case `wb_en` stays low and `prod`, `flag_z` and `flag_c` keep their previous values.
- R9: A legal operation raises `wb_en` together with `done` and presents the result on `prod`, low byte bound for register 0 and high byte for register 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch an operation (sampled while idle) |
| mode | input | 3 | bit 2 fractional, bits 1:0 base mode (00 UU, 01 SS, 10 SU, 11 reserved) |
| idx_a | input | 5 | Register index of the first operand |
| idx_b | input | 5 | Register index of the second operand |
| op_a | input | 8 | First operand value |
| op_b | input | 8 | Second operand value |
| busy | output | 1 | Operation in flight |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Completion without writeback due to illegal index or mode |
| wb_en | output | 1 | Product valid for writeback |
| prod | output | 16 | Product, low byte to register 0, high byte to register 1 |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |

## Verification
Several corner cases need direct stimulus. -128 times -128 becomes 0x8000 after the fractional shift while carry stays 0, so a design that took carry after the shift would report 1 there. 255 times 255 in fractional unsigned mode moves a set bit 15 out of the result, so a wrong shift or a carry taken late shows up in `prod` or `flag_c`. The index checks are probed at the window edges 15/16, 23/24 and 31, and in unsigned mode with indices 0 and 31. An off-by-one window would either write back an illegal operation or refuse a legal one. In the busy cycle the bench drives a second `start` with different operands. If that strobe were accepted, an extra `done` would appear or the result would be corrupted.

// File: rtl/mulx_pkg.sv
package mulx_pkg;

  typedef enum logic [1:0] {
    MX_UU  = 2'b00,
    MX_SS  = 2'b01,
    MX_SU  = 2'b10,
    MX_BAD = 2'b11
  } mx_kind_e;

  typedef struct packed {
    logic     frac;
    mx_kind_e kind;
  } mx_mode_t;

endpackage

// File: rtl/mulx_regchk.sv
module mulx_regchk
  import mulx_pkg::*;
#(
  parameter int IDX_W       = 5,
  parameter int HI_BASE     = 16,
  parameter int WIDE_SPAN   = 16,
  parameter int NARROW_SPAN = 8
) (
  input  mx_mode_t         mode,
  input  logic [IDX_W-1:0] idx_a,
  input  logic [IDX_W-1:0] idx_b,
  output logic             ok
);
  localparam int WIDE_TOP   = HI_BASE + WIDE_SPAN - 1;
  localparam int NARROW_TOP = HI_BASE + NARROW_SPAN - 1;

  logic [IDX_W-1:0] idx [2];
  logic [1:0]       in_wide;
  logic [1:0]       in_narrow;

  assign idx[0] = idx_a;
  assign idx[1] = idx_b;

  for (genvar g = 0; g < 2; g++) begin : g_win
    assign in_wide[g]   = (int'(idx[g]) >= HI_BASE) && (int'(idx[g]) <= WIDE_TOP);
    assign in_narrow[g] = (int'(idx[g]) >= HI_BASE) && (int'(idx[g]) <= NARROW_TOP);
  end

  always_comb begin
    ok = 1'b0;
    unique case (mode.kind)
      MX_UU:   ok = mode.frac ? (&in_narrow) : 1'b1;
      MX_SS:   ok = mode.frac ? (&in_narrow) : (&in_wide);
      MX_SU:   ok = &in_narrow;
      default: ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/mulx_opext.sv
module mulx_opext
  import mulx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  mx_kind_e                kind,
  input  logic [DATA_W-1:0]       a,
  input  logic [DATA_W-1:0]       b,
  output logic signed [DATA_W:0]  xa,
  output logic signed [DATA_W:0]  xb
);
  logic a_sgn;
  logic b_sgn;

  assign a_sgn = (kind == MX_SS) || (kind == MX_SU);
  assign b_sgn = (kind == MX_SS);

  assign xa = $signed({a_sgn & a[DATA_W-1], a});
  assign xb = $signed({b_sgn & b[DATA_W-1], b});
endmodule

// File: rtl/mulx_core.sv
module mulx_core #(
  parameter int DATA_W = 8
) (
  input  logic signed [DATA_W:0]   xa,
  input  logic signed [DATA_W:0]   xb,
  input  logic                     frac,
  output logic [2*DATA_W-1:0]      res,
  output logic                     z,
  output logic                     c
);
  localparam int PROD_W = 2 * DATA_W;

  logic signed [PROD_W-1:0] wa;
  logic signed [PROD_W-1:0] wb;
  logic [PROD_W-1:0]        raw;

  assign wa  = $signed({{(DATA_W-1){xa[DATA_W]}}, xa});
  assign wb  = $signed({{(DATA_W-1){xb[DATA_W]}}, xb});
  assign raw = wa * wb;

  assign c   = raw[PROD_W-1];
  assign res = frac ? {raw[PROD_W-2:0], 1'b0} : raw;
  assign z   = (res == '0);
endmodule

// File: rtl/mulx_unit.sv
module mulx_unit
  import mulx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int IDX_W       = 5,
  parameter int HI_BASE     = 16,
  parameter int WIDE_SPAN   = 16,
  parameter int NARROW_SPAN = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [2:0]            mode,
  input  logic [IDX_W-1:0]      idx_a,
  input  logic [IDX_W-1:0]      idx_b,
  input  logic [DATA_W-1:0]     op_a,
  input  logic [DATA_W-1:0]     op_b,
  output logic                  busy,
  output logic                  done,
  output logic                  err,
  output logic                  wb_en,
  output logic [2*DATA_W-1:0]   prod,
  output logic                  flag_z,
  output logic                  flag_c
);
  localparam int PROD_W = 2 * DATA_W;

  mx_mode_t              mode_q;
  logic                  ok_d;
  logic signed [DATA_W:0] xa_d, xb_d;
  logic signed [DATA_W:0] s1_xa, s1_xb;
  logic                  s1_frac;
  logic                  s1_ok;
  logic [PROD_W-1:0]     res_d;
  logic                  z_d, c_d;

  assign mode_q = mx_mode_t'(mode);

  mulx_regchk #(
    .IDX_W(IDX_W), .HI_BASE(HI_BASE),
    .WIDE_SPAN(WIDE_SPAN), .NARROW_SPAN(NARROW_SPAN)
  ) u_regchk (
    .mode(mode_q), .idx_a(idx_a), .idx_b(idx_b), .ok(ok_d)
  );

  mulx_opext #(.DATA_W(DATA_W)) u_opext (
    .kind(mode_q.kind), .a(op_a), .b(op_b), .xa(xa_d), .xb(xb_d)
  );

  mulx_core #(.DATA_W(DATA_W)) u_core (
    .xa(s1_xa), .xb(s1_xb), .frac(s1_frac),
    .res(res_d), .z(z_d), .c(c_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
      wb_en   <= 1'b0;
      prod    <= '0;
      flag_z  <= 1'b0;
      flag_c  <= 1'b0;
      s1_xa   <= '0;
      s1_xb   <= '0;
      s1_frac <= 1'b0;
      s1_ok   <= 1'b0;
    end else begin
      done  <= 1'b0;
      err   <= 1'b0;
      wb_en <= 1'b0;
      if (busy) begin
        busy <= 1'b0;
        done <= 1'b1;
        if (s1_ok) begin
          prod   <= res_d;
          flag_z <= z_d;
          flag_c <= c_d;
          wb_en  <= 1'b1;
        end else begin
          err <= 1'b1;
        end
      end else if (start) begin
        busy    <= 1'b1;
        s1_xa   <= xa_d;
        s1_xb   <= xb_d;
        s1_frac <= mode_q.frac;
        s1_ok   <= ok_d;
      end
    end
  end
endmodule

// File: rtl/mulx_unit_chk.sv
module mulx_unit_chk #(
  parameter int PROD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              wb_en,
  input logic [PROD_W-1:0] prod,
  input logic              flag_z,
  input logic              flag_c
);
  AST_START_TO_BUSY: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy) else $error("start"); // R7
  AST_BUSY_TO_DONE: assert property (@(posedge clk) disable iff (rst)
    busy |=> (done && !busy)) else $error("done"); // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) else $error("pulse"); // R7
  AST_WB_XOR_ERR: assert property (@(posedge clk) disable iff (rst)
    done |-> (wb_en != err)) else $error("wb/err"); // R9
  AST_WB_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
    (wb_en || err) |-> done) else $error("stray"); // R8
  AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (rst)
    err |-> ($stable(prod) && $stable(flag_z) && $stable(flag_c))) else $error("hold"); // R8
  AST_Z_CONSISTENT: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> (flag_z == (prod == '0))) else $error("zero"); // R6
endmodule

bind mulx_unit mulx_unit_chk #(.PROD_W(2*DATA_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .err(err), .wb_en(wb_en), .prod(prod), .flag_z(flag_z), .flag_c(flag_c)
);

// File: tb/mulx_unit_tb.sv
module mulx_unit_tb;
  logic        clk = 0;
  logic        rst = 1;
  logic        start = 0;
  logic [2:0]  mode = 0;
  logic [4:0]  idx_a = 0, idx_b = 0;
  logic [7:0]  op_a = 0, op_b = 0;
  logic        busy, done, err, wb_en, flag_z, flag_c;
  logic [15:0] prod;

  int total = 0;
  int fails = 0;
  bit finished = 0;

  logic [15:0] e_prod = 0;
  logic        e_z = 0, e_c = 0;

  always #2.5 clk = ~clk;

  mulx_unit u_dut (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .idx_a(idx_a), .idx_b(idx_b),
    .op_a(op_a), .op_b(op_b), .busy(busy), .done(done), .err(err), .wb_en(wb_en),
    .prod(prod), .flag_z(flag_z), .flag_c(flag_c)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit in_win(input int i, input int lo, input int hi);
    return i >= lo && i <= hi;
  endfunction

  function automatic bit legal(input logic [2:0] m, input int ia, input int ib);
    case (m[1:0])
      2'b00: return m[2] ? (in_win(ia,16,23) && in_win(ib,16,23)) : 1'b1;
      2'b01: return m[2] ? (in_win(ia,16,23) && in_win(ib,16,23))
                         : (in_win(ia,16,31) && in_win(ib,16,31));
      2'b10: return in_win(ia,16,23) && in_win(ib,16,23);
      default: return 1'b0;
    endcase
  endfunction

  function automatic int raw_prod(input logic [2:0] m, input logic [7:0] a, input logic [7:0] b);
    int sa, sb;
    sa = int'(a);
    sb = int'(b);
    if ((m[1:0] == 2'b01 || m[1:0] == 2'b10) && a[7]) sa = sa - 256;
    if (m[1:0] == 2'b01 && b[7]) sb = sb - 256;
    return (sa * sb) & 32'hFFFF;
  endfunction

  task automatic run_op(input logic [2:0] m, input logic [7:0] a, input logic [7:0] b,
                        input logic [4:0] ia, input logic [4:0] ib, input bit poke,
                        input string tag);
    bit lg;
    int raw;
    logic [15:0] res;
    @(negedge clk);
    mode = m; op_a = a; op_b = b; idx_a = ia; idx_b = ib; start = 1;
    @(negedge clk);
    chk(busy === 1'b1, "R7 busy", busy, 1);
    if (poke) begin
      mode = 3'b000; op_a = ~a; op_b = b ^ 8'h5A; idx_a = 0; idx_b = 0; start = 1;
    end else start = 0;
    lg  = legal(m, ia, ib);
    raw = raw_prod(m, a, b);
    res = m[2] ? 16'((raw << 1) & 32'hFFFF) : 16'(raw);
    if (lg) begin
      e_prod = res;
      e_c = raw[15];
      e_z = (res == 16'h0);
    end
    @(negedge clk);
    start = 0;
    chk(done === 1'b1, {tag, " R7 done"}, done, 1);
    chk(err === !lg, {tag, " R8 err"}, err, !lg);
    chk(wb_en === lg, {tag, " R9 wb_en"}, wb_en, lg);
    chk(prod === e_prod, {tag, " prod"}, prod, e_prod);
    chk(flag_z === e_z, {tag, " R6 z"}, flag_z, e_z);
    chk(flag_c === e_c, {tag, " R6 c"}, flag_c, e_c);
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, {tag, " R7 quiet"}, {done, busy}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(busy === 0 && done === 0 && err === 0 && wb_en === 0, "R1 ctrl", {busy,done,err,wb_en}, 0);
    chk(prod === 0 && flag_z === 0 && flag_c === 0, "R1 data", prod, 0);
    rst = 0;
    @(negedge clk);
    chk(busy === 0 && done === 0 && prod === 0, "R1 after", {busy,done}, 0);

    // directed corners
    run_op(3'b000, 8'd255, 8'd255, 5'd0,  5'd31, 0, "R2 max idx0/31");
    run_op(3'b000, 8'd0,   8'd77,  5'd5,  5'd9,  1, "R2 zero poke");
    run_op(3'b001, 8'h80,  8'h80,  5'd16, 5'd31, 0, "R3 -128sq");
    run_op(3'b001, 8'h80,  8'h7F,  5'd15, 5'd20, 0, "R3 idx15");
    run_op(3'b001, 8'hFF,  8'h02,  5'd31, 5'd16, 1, "R3 neg");
    run_op(3'b010, 8'hFF,  8'hFF,  5'd16, 5'd23, 0, "R4 mix");
    run_op(3'b010, 8'h10,  8'h10,  5'd24, 5'd16, 0, "R4 idx24");
    run_op(3'b101, 8'h80,  8'h80,  5'd16, 5'd23, 0, "R5 frac ss 8000");
    run_op(3'b100, 8'd255, 8'd255, 5'd17, 5'd18, 0, "R5 frac uu");
    run_op(3'b100, 8'd3,   8'd3,   5'd0,  5'd18, 0, "R5 frac uu idx0");
    run_op(3'b101, 8'h01,  8'h01,  5'd24, 5'd16, 0, "R5 frac ss idx24");
    run_op(3'b110, 8'h80,  8'hFF,  5'd23, 5'd16, 1, "R5 frac su");
    run_op(3'b011, 8'h12,  8'h34,  5'd16, 5'd16, 0, "R8 bad mode");
    run_op(3'b111, 8'h12,  8'h34,  5'd16, 5'd16, 0, "R8 bad frac mode");

    for (int n = 0; n < 300; n++) begin
      logic [2:0] m;
      logic [4:0] ia, ib;
      m = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 9) < 7) begin
        ia = 5'(16 + $urandom_range(0, 7));
        ib = 5'(16 + $urandom_range(0, 7));
      end else begin
        ia = 5'($urandom_range(0, 31));
        ib = 5'($urandom_range(0, 31));
      end
      run_op(m, 8'($urandom), 8'($urandom), ia, ib, bit'($urandom_range(0, 1)), "R2 R3 R4 R5 rnd");
    end

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule